// File: doc/BRIEF.md
# AC-link Record Frame Deserializer

This block sits on the receive side of a codec link. The codec sends one serial stream that is timed by the codec's bit clock and marked by a frame sync. The block cuts each frame of that stream into its fields and places them on parallel outputs.

A frame opens with a 16-bit tag, and twelve 20-bit slots follow it. The tag reports which parts of the frame carry data. The block keeps the codec-ready indication from the tag. It takes the register status word from slot 2 and the left and right record samples from slots 3 and 4. Each of these three fields has its own single-cycle valid strobe, and the tag gates that strobe. The remaining slots are shifted in and then dropped. Serial input is sampled on the falling edge of the bit clock. All outputs change on the rising edge.

Top module: `acrx_deserializer`

## Requirements
- R1: Reset is asynchronous and active high. It clears codecReady, every data output and every valid strobe to 0.
- R2: A frame starts when the block sees syncIn high on a falling edge after it saw syncIn low on the previous falling edge. The serialIn bit sampled on that edge is frame bit 0. Bits arrive MSB first: bits 0..15 form the tag (bit 0 is tag bit 15), bits 16..35 form slot 1, bits 36..55 slot 2, bits 56..75 slot 3 and bits 76..95 slot 4.
- R3: codecReady takes the value of tag bit 15 once the last tag bit has been taken in. It keeps that value until the next complete tag arrives.
- R4: regData is loaded with bits 19..4 of slot 2. regValid pulses only when both tag bits 15 and 13 of the same frame are 1.
- R5: leftData is loaded with bits 19..4 of slot 3. leftValid pulses only when both tag bits 15 and 12 are 1.
- R6: rightData is loaded with bits 19..4 of slot 4. rightValid pulses only when both tag bits 15 and 11 are 1.
- R7: Each valid strobe is high for exactly one cycle. It rises on the rising edge that follows the falling edge that sampled the slot's last bit, so it appears 55, 75 or 95 cycles after frame bit 0 is registered. At most one strobe is high in any cycle.
- R8: A data output does not change in a frame where its valid strobe is suppressed.
- R9: Slots 5 to 12, and any bits that arrive after bit 255 without a new sync, change no output.
- R10: A new sync edge before bit 255 drops the unfinished frame and restarts counting at bit 0. This holds even when the sync edge falls on the bit that would have ended a slot, and no strobe is then raised for that slot.
- R11: A frame is 256 bits long. A sync edge that arrives on the bit directly after bit 255 starts the next frame with no gap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| bitClk | input | 1 | Serial bit clock from the codec |
| rst | input | 1 | Asynchronous reset, active high |
| syncIn | input | 1 | Frame sync; a rising level marks frame bit 0 |
| serialIn | input | 1 | Serial record stream, MSB first |
| codecReady | output | 1 | Tag bit 15 of the most recent complete tag |
| regData | output | 16 | Register status word from slot 2 |
| regValid | output | 1 | One-cycle strobe for regData |
| leftData | output | 16 | Left record sample from slot 3 |
| leftValid | output | 1 | One-cycle strobe for leftData |
| rightData | output | 16 | Right record sample from slot 4 |
| rightValid | output | 1 | One-cycle strobe for rightData |

## Verification
Restarting on a new sync edge and closing a slot can both happen on the same bit. To provoke this, the bench sends exactly 55 bits of a frame whose tag flags slot 2, so the next sync edge lands on the bit that would have closed slot 2. It then passes when no register strobe ever appears, and when the strobe of the new frame comes 95 cycles after that frame's own bit 0. A back-to-back frame pair also puts the bit-255 wrap and a sync edge on the same cycle. That case is judged by the second frame's samples and strobes.

// File: rtl/acrx_pkg.sv
package acrx_pkg;
  parameter int TAG_BITS    = 16;
  parameter int SLOT_BITS   = 20;
  parameter int SLOT_COUNT  = 12;
  parameter int PCM_BITS    = 16;
  parameter int FIRST_SLOT  = 2;  // first slot whose payload is decoded
  parameter int DATA_SLOTS  = 3;  // slots 2, 3, 4
  parameter int FRAME_BITS  = TAG_BITS + SLOT_COUNT * SLOT_BITS;
  parameter int CNT_W       = $clog2(FRAME_BITS);

  typedef struct packed {
    logic                  shiftEn;   // a frame bit was taken this edge
    logic                  tagDone;   // last tag bit taken this edge
    logic [DATA_SLOTS-1:0] slotDone;  // last bit of slot FIRST_SLOT+j taken
  } ctl_t;
endpackage

// File: rtl/acrx_control.sv
module acrx_control
  import acrx_pkg::*;
(
  input  logic bitClk,
  input  logic rst,
  input  logic syncIn,
  input  logic serialIn,
  output logic dataBit,
  output ctl_t ctl
);
  logic             syncSmp;
  logic             syncPrev;
  logic             inFrame;
  logic [CNT_W-1:0] bitPos;
  logic [CNT_W-1:0] curPos;
  logic             syncRise;
  logic             advance;
  logic             take;
  logic [DATA_SLOTS-1:0] slotHit;

  localparam logic [CNT_W-1:0] LAST_POS = CNT_W'(FRAME_BITS - 1);
  localparam logic [CNT_W-1:0] TAG_END  = CNT_W'(TAG_BITS - 1);

  // input sampling on the falling edge
  always_ff @(negedge bitClk or posedge rst) begin
    if (rst) begin
      syncSmp <= 1'b0;
      dataBit <= 1'b0;
    end else begin
      syncSmp <= syncIn;
      dataBit <= serialIn;
    end
  end

  assign syncRise = syncSmp & ~syncPrev;
  assign advance  = inFrame && (bitPos != LAST_POS);
  assign take     = syncRise | advance;
  assign curPos   = syncRise ? '0 : bitPos + 1'b1;

  always_ff @(posedge bitClk or posedge rst) begin
    if (rst) begin
      syncPrev <= 1'b0;
      inFrame  <= 1'b0;
      bitPos   <= '0;
    end else begin
      syncPrev <= syncSmp;
      inFrame  <= take;
      if (take) bitPos <= curPos;
    end
  end

  for (genvar j = 0; j < DATA_SLOTS; j++) begin : g_slotEnd
    localparam logic [CNT_W-1:0] SLOT_END =
      CNT_W'(TAG_BITS + (FIRST_SLOT + j) * SLOT_BITS - 1);
    assign slotHit[j] = take && (curPos == SLOT_END);
  end

  assign ctl.shiftEn  = take;
  assign ctl.tagDone  = take && (curPos == TAG_END);
  assign ctl.slotDone = slotHit;

  // R7: field boundaries never coincide
  p_single_boundary_r7: assert property (@(posedge bitClk) disable iff (rst)
    $onehot0({ctl.tagDone, ctl.slotDone}));

  // R10: a sync edge always restarts at bit 0 on the next cycle
  p_restart_r10: assert property (@(posedge bitClk) disable iff (rst)
    syncRise |=> (bitPos == '0) && inFrame);

  // R11: without a new sync the frame ends after bit 255
  p_frame_end_r11: assert property (@(posedge bitClk) disable iff (rst)
    (inFrame && bitPos == LAST_POS && !syncRise) |=> !inFrame);
endmodule

// File: rtl/acrx_datapath.sv
module acrx_datapath
  import acrx_pkg::*;
(
  input  logic                bitClk,
  input  logic                rst,
  input  logic                dataBit,
  input  ctl_t                ctl,
  output logic                codecReady,
  output logic [PCM_BITS-1:0] regData,
  output logic                regValid,
  output logic [PCM_BITS-1:0] leftData,
  output logic                leftValid,
  output logic [PCM_BITS-1:0] rightData,
  output logic                rightValid
);
  logic [SLOT_BITS-2:0]  shiftReg;
  logic [SLOT_BITS-1:0]  field;
  logic                  frameOk;
  logic [DATA_SLOTS-1:0] slotFlag;
  logic [PCM_BITS-1:0]   capData  [DATA_SLOTS];
  logic [DATA_SLOTS-1:0] capValid;

  assign field = {shiftReg, dataBit};

  always_ff @(posedge bitClk or posedge rst) begin
    if (rst) shiftReg <= '0;
    else if (ctl.shiftEn) shiftReg <= field[SLOT_BITS-2:0];
  end

  // tag capture: frame flag is the tag MSB, slot flags follow below it
  always_ff @(posedge bitClk or posedge rst) begin
    if (rst) begin
      frameOk    <= 1'b0;
      slotFlag   <= '0;
      codecReady <= 1'b0;
    end else if (ctl.tagDone) begin
      frameOk    <= field[TAG_BITS-1];
      codecReady <= field[TAG_BITS-1];
      for (int j = 0; j < DATA_SLOTS; j++)
        slotFlag[j] <= field[TAG_BITS-1-FIRST_SLOT-j];
    end
  end

  for (genvar j = 0; j < DATA_SLOTS; j++) begin : g_capture
    logic fire;
    assign fire = ctl.slotDone[j] && frameOk && slotFlag[j];
    always_ff @(posedge bitClk or posedge rst) begin
      if (rst) begin
        capData[j]  <= '0;
        capValid[j] <= 1'b0;
      end else begin
        capValid[j] <= fire;
        if (fire) capData[j] <= field[SLOT_BITS-1 -: PCM_BITS];
      end
    end
  end

  assign regData    = capData[0];
  assign regValid   = capValid[0];
  assign leftData   = capData[1];
  assign leftValid  = capValid[1];
  assign rightData  = capData[2];
  assign rightValid = capValid[2];

  // R3: ready only moves when the control reports a completed tag
  p_ready_hold_r3: assert property (@(posedge bitClk) disable iff (rst)
    !ctl.tagDone |=> $stable(codecReady));

  // R4: register strobe implies the frame and slot-2 flags were set
  p_reg_gate_r4: assert property (@(posedge bitClk) disable iff (rst)
    regValid |-> (frameOk && slotFlag[0]));

  // R7: strobes are exclusive and last one cycle
  p_strobe_exclusive_r7: assert property (@(posedge bitClk) disable iff (rst)
    $onehot0({regValid, leftValid, rightValid}));
  p_left_pulse_r7: assert property (@(posedge bitClk) disable iff (rst)
    leftValid |=> !leftValid);

  // R8: data words hold unless their slot just closed
  p_reg_hold_r8: assert property (@(posedge bitClk) disable iff (rst)
    !ctl.slotDone[0] |=> $stable(regData));
  p_right_hold_r8: assert property (@(posedge bitClk) disable iff (rst)
    !ctl.slotDone[2] |=> $stable(rightData));
endmodule

// File: rtl/acrx_deserializer.sv
module acrx_deserializer
  import acrx_pkg::*;
(
  input  logic                bitClk,
  input  logic                rst,
  input  logic                syncIn,
  input  logic                serialIn,
  output logic                codecReady,
  output logic [PCM_BITS-1:0] regData,
  output logic                regValid,
  output logic [PCM_BITS-1:0] leftData,
  output logic                leftValid,
  output logic [PCM_BITS-1:0] rightData,
  output logic                rightValid
);
  logic dataBit;
  ctl_t ctl;

  acrx_control i_control (
    .bitClk   (bitClk),
    .rst      (rst),
    .syncIn   (syncIn),
    .serialIn (serialIn),
    .dataBit  (dataBit),
    .ctl      (ctl)
  );

  acrx_datapath i_datapath (
    .bitClk     (bitClk),
    .rst        (rst),
    .dataBit    (dataBit),
    .ctl        (ctl),
    .codecReady (codecReady),
    .regData    (regData),
    .regValid   (regValid),
    .leftData   (leftData),
    .leftValid  (leftValid),
    .rightData  (rightData),
    .rightValid (rightValid)
  );
endmodule

// File: tb/test_acrx_deserializer.sv
`timescale 1ns/1ps
module test_acrx_deserializer;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        syncLine = 1'b0;
  logic        dataLine = 1'b0;
  logic        codecReady, regValid, leftValid, rightValid;
  logic [15:0] regData, leftData, rightData;

  int checks = 0;
  int errors = 0;
  int cycleCnt = 0;
  int regCnt = 0, leftCnt = 0, rightCnt = 0;
  int regAt = 0, leftAt = 0, rightAt = 0;
  logic [15:0] regSeen = '0, leftSeen = '0, rightSeen = '0;
  bit done = 0;

  always #5 clk = ~clk;

  acrx_deserializer i_acrx_deserializer (
    .bitClk(clk), .rst(rst), .syncIn(syncLine), .serialIn(dataLine),
    .codecReady(codecReady), .regData(regData), .regValid(regValid),
    .leftData(leftData), .leftValid(leftValid),
    .rightData(rightData), .rightValid(rightValid)
  );

  always @(posedge clk) cycleCnt <= cycleCnt + 1;

  // pulse monitor, sampled mid-cycle
  always @(negedge clk) begin
    if (regValid)   begin regCnt++;   regAt = cycleCnt;   regSeen = regData;     end
    if (leftValid)  begin leftCnt++;  leftAt = cycleCnt;  leftSeen = leftData;   end
    if (rightValid) begin rightCnt++; rightAt = cycleCnt; rightSeen = rightData; end
  end

  task automatic check(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic clearMon();
    regCnt = 0; leftCnt = 0; rightCnt = 0;
  endtask

  task automatic driveBit(input logic s, input logic d);
    syncLine = s;
    dataLine = d;
    @(posedge clk); #1;
  endtask

  task automatic sendFrame(input logic [15:0] tag, input logic [19:0] s2,
                           input logic [19:0] s3, input logic [19:0] s4,
                           input logic [19:0] tail, input int nbits,
                           output int base);
    logic [255:0] v;
    v = {tag, 20'h00000, s2, s3, s4, {8{tail}}};
    base = 0;
    for (int i = 0; i < nbits; i++) begin
      driveBit(i < 16, v[255-i]);
      if (i == 0) base = cycleCnt;
    end
  endtask

  task automatic idleBits(input int n);
    for (int i = 0; i < n; i++) driveBit(1'b0, i[0] ^ i[2]);
  endtask

  task automatic t_reset();
    check(codecReady == 0, "R1", "codecReady", codecReady, 0);
    check({regValid, leftValid, rightValid} == 0, "R1", "strobes",
          {regValid, leftValid, rightValid}, 0);
    check({regData, leftData, rightData} == 0, "R1", "data",
          {regData, leftData}, 0);
  endtask

  task automatic t_fullFrame();
    int base;
    clearMon();
    sendFrame(16'hB800, 20'hFEDCB, 20'h80010, 20'h12340, 20'hA5A5A, 256, base);
    idleBits(4);
    check(codecReady == 1, "R3", "codecReady", codecReady, 1);
    check(regCnt == 1 && regSeen == 16'hFEDC, "R4", "reg word", regSeen, 16'hFEDC);
    check(leftCnt == 1 && leftSeen == 16'h8001, "R5", "left", leftSeen, 16'h8001);
    check(rightCnt == 1 && rightSeen == 16'h1234, "R6", "right", rightSeen, 16'h1234);
    check(regAt - base == 55, "R7", "reg offset", regAt - base, 55);
    check(leftAt - base == 75, "R7", "left offset", leftAt - base, 75);
    check(rightAt - base == 95, "R2", "right offset", rightAt - base, 95);
  endtask

  task automatic t_tagGating();
    int base;
    clearMon();
    sendFrame(16'h9800, 20'h11111, 20'h2468A, 20'h13579, 20'h0F0F0, 256, base);
    idleBits(4);
    check(regCnt == 0, "R4", "reg strobe without bit13", regCnt, 0);
    check(regData == 16'hFEDC, "R8", "reg held", regData, 16'hFEDC);
    check(leftCnt == 1 && leftSeen == 16'h2468, "R5", "left", leftSeen, 16'h2468);
    check(rightCnt == 1 && rightSeen == 16'h1357, "R6", "right", rightSeen, 16'h1357);
    clearMon();
    sendFrame(16'h3800, 20'h55555, 20'h66666, 20'h77777, 20'h00000, 256, base);
    idleBits(4);
    check(codecReady == 0, "R3", "codecReady cleared", codecReady, 0);
    check(regCnt + leftCnt + rightCnt == 0, "R5", "strobes with bit15 clear",
          regCnt + leftCnt + rightCnt, 0);
    check(leftData == 16'h2468, "R8", "left held", leftData, 16'h2468);
  endtask

  task automatic t_tail();
    int base;
    clearMon();
    sendFrame(16'h8000, 20'hFFFFF, 20'hFFFFF, 20'hFFFFF, 20'hFFFFF, 256, base);
    idleBits(300);
    check(regCnt + leftCnt + rightCnt == 0, "R9", "strobes from tail/idle",
          regCnt + leftCnt + rightCnt, 0);
    check(codecReady == 1, "R9", "codecReady after idle", codecReady, 1);
    check(rightData == 16'h1357, "R9", "right untouched", rightData, 16'h1357);
  endtask

  task automatic t_resync();
    int base;
    clearMon();
    // 55 bits: the restart lands on the bit that would close slot 2
    sendFrame(16'hB800, 20'hCAFE1, 20'h00000, 20'h00000, 20'h00000, 55, base);
    sendFrame(16'h8800, 20'hBEEF0, 20'h3C3C0, 20'hABCD0, 20'h00000, 256, base);
    idleBits(4);
    check(regCnt == 0, "R10", "reg strobe from dropped frame", regCnt, 0);
    check(regData == 16'hFEDC, "R10", "reg word kept", regData, 16'hFEDC);
    check(leftCnt == 0, "R10", "left strobe", leftCnt, 0);
    check(rightCnt == 1 && rightSeen == 16'hABCD, "R10", "right", rightSeen, 16'hABCD);
    check(rightAt - base == 95, "R10", "right offset", rightAt - base, 95);
  endtask

  task automatic t_backToBack();
    int b1, b2;
    clearMon();
    sendFrame(16'h9000, 20'h00000, 20'h11110, 20'h00000, 20'h00000, 256, b1);
    sendFrame(16'h8800, 20'h00000, 20'h00000, 20'h22220, 20'h00000, 256, b2);
    idleBits(4);
    check(b2 - b1 == 256, "R11", "frame spacing", b2 - b1, 256);
    check(leftCnt == 1 && leftSeen == 16'h1111, "R11", "left", leftSeen, 16'h1111);
    check(rightCnt == 1 && rightSeen == 16'h2222, "R11", "right", rightSeen, 16'h2222);
    check(rightAt - b2 == 95, "R11", "second frame offset", rightAt - b2, 95);
  endtask

  task automatic t_midReset();
    int base;
    sendFrame(16'hB800, 20'h12340, 20'h56780, 20'h9ABC0, 20'h00000, 256, base);
    idleBits(2);
    rst = 1'b1;
    @(posedge clk); #1;
    t_reset();
    rst = 1'b0;
    idleBits(2);
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      done = 1;
      checks++; errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    t_reset();
    rst = 1'b0;
    idleBits(3);
    t_reset();
    t_fullFrame();
    t_tagGating();
    t_tail();
    t_resync();
    t_backToBack();
    t_midReset();
    if (!done) begin
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule